// File: doc/BRIEF.md
# Fabric protected-range access checker

This block guards a memory-mapped fabric target with a 64 KB address space. Two range slots each describe a protected window by a base address, a power-of-two size, an owning requester ID, an enable bit and a lock bit. Every transaction is presented as an address, a requester ID and a direction flag. One cycle later the block answers whether it may proceed and which slot, if any, claimed it. Addresses outside every enabled window are open to all requesters. A whole window is protected, including any part of it that holds no data.

Software programs the slots through a single-cycle write port. Each write is screened before it takes effect. A base that is not aligned to the chosen size is refused. A window that would intersect the other enabled window is refused. A write to a locked slot is dropped. A refused write leaves the slot as it was and raises a sticky error flag, so the two protected windows can never share an address.

Top module: `fabric_range_guard`

## Requirements
- R1: After reset both slots are disabled and unlocked, both error flags are 0, and any transaction is answered with rsp_allow=1 and rsp_hit=0.
- R2: The size code selects the window length: 0 gives 4 KB, 1 gives 8 KB, 2 gives 16 KB and 3 gives 32 KB. An enabled window covers every address from base up to base+length-1, including unused padding.
- R3: A transaction presented with tx_valid=1 is answered exactly one cycle later with rsp_valid=1. In a cycle with no answer, rsp_valid, rsp_allow, rsp_hit, rsp_idx and rsp_write are all 0.
- R4: An address inside an enabled window gets rsp_hit=1, and rsp_idx gives the slot number (0 or 1). It gets rsp_allow=1 only when tx_id equals that slot's owner.
- R5: An address outside every enabled window gets rsp_allow=1, rsp_hit=0 and rsp_idx=0, whatever the requester.
- R6: A configuration write whose base is not a multiple of the selected length is refused. The slot is unchanged and cfg_err_align is set and stays set until reset.
- R7: A configuration write with cfg_en=1 is refused when the other slot is enabled and each window's base is below the other window's end. The slot is unchanged and cfg_err_overlap is set and stays set until reset. Windows that only touch (one ends where the other starts) are accepted. Alignment is judged first, so a misaligned write raises only cfg_err_align.
- R8: An accepted write with cfg_lock=1 locks its slot. Later writes to a locked slot are ignored without raising any error flag, until reset.
- R9: tx_write does not affect the decision. Its value is returned on rsp_write together with the answer.
- R10: A disabled slot protects nothing. A write with cfg_en=0 skips the overlap screen but is still checked for alignment.
- R11: A configuration write in cycle N governs transactions presented from cycle N+1 on. A transaction presented in cycle N is judged with the slot contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Slot addressed by the write |
| cfg_base | input | 16 | New window base address |
| cfg_size | input | 2 | New size code |
| cfg_owner | input | 4 | New owning requester ID |
| cfg_en | input | 1 | New enable bit |
| cfg_lock | input | 1 | Lock the slot if the write is accepted |
| tx_valid | input | 1 | Transaction present |
| tx_addr | input | 16 | Transaction address |
| tx_id | input | 4 | Requester ID |
| tx_write | input | 1 | Direction flag, 1 for write |
| rsp_valid | output | 1 | Answer present |
| rsp_allow | output | 1 | Transaction may proceed |
| rsp_hit | output | 1 | Address fell inside an enabled window |
| rsp_idx | output | 1 | Slot that claimed the address |
| rsp_write | output | 1 | Direction flag of the answered transaction |
| cfg_err_align | output | 1 | Sticky: a misaligned write was refused |
| cfg_err_overlap | output | 1 | Sticky: an overlapping write was refused |

## Verification
The hardest situation to reach is a refused write whose slot contents must be shown to be unchanged. The only view into the slots is the transaction path. So each refusal is followed by transactions aimed at the old window's interior and padding, and at the rejected window, with requester IDs that tell the owners apart. Touching windows need the other slot already sitting at the exact boundary, so the stimulus builds the 32 KB slot first and then places the small one flush against it. A long random phase then mixes writes, locks and transactions against a behavioural model, so that rarer orderings also occur, such as a write and a transaction in the same cycle.

// File: rtl/frg_pkg.sv
package frg_pkg;

    localparam int ADDR_W    = 16;
    localparam int ID_W      = 4;
    localparam int SIZE_W    = 2;
    localparam int MIN_SHIFT = 12;
    localparam int SLOTS     = 2;
    localparam int IDX_W     = $clog2(SLOTS);

    typedef struct packed {
        logic              en;
        logic              lock;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [ID_W-1:0]   owner;
    } range_t;

    function automatic logic [ADDR_W:0] span(input logic [SIZE_W-1:0] code);
        logic [ADDR_W:0] one;
        one = {{ADDR_W{1'b0}}, 1'b1};
        return one << (MIN_SHIFT + int'(code));
    endfunction

    function automatic logic [ADDR_W:0] range_end(input logic [ADDR_W-1:0] base,
                                                  input logic [SIZE_W-1:0] code);
        return {1'b0, base} + span(code);
    endfunction

    function automatic logic is_aligned(input logic [ADDR_W-1:0] base,
                                        input logic [SIZE_W-1:0] code);
        logic [ADDR_W:0] mask;
        mask = span(code) - 1'b1;
        return ({1'b0, base} & mask) == '0;
    endfunction

    function automatic logic windows_meet(input logic [ADDR_W-1:0] base_a,
                                          input logic [SIZE_W-1:0] code_a,
                                          input logic [ADDR_W-1:0] base_b,
                                          input logic [SIZE_W-1:0] code_b);
        return ({1'b0, base_a} < range_end(base_b, code_b)) &&
               ({1'b0, base_b} < range_end(base_a, code_a));
    endfunction

endpackage

// File: rtl/frg_range_slot.sv
module frg_range_slot
    import frg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  range_t load_val,
    output range_t slot_q
);

    range_t slot_d;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // R8: a locked slot never changes until reset
    a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slot_q.lock) |-> $stable(slot_q));

    // R6: a stored base is always aligned to its own length
    a_r6_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        is_aligned(slot_q.base, slot_q.size));

endmodule

// File: rtl/frg_cfg_check.sv
module frg_cfg_check
    import frg_pkg::*;
(
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_sel,
    input  range_t                cand,
    input  range_t [SLOTS-1:0]    slots,
    output logic   [SLOTS-1:0]    load,
    output logic                  set_align,
    output logic                  set_overlap
);

    logic       active;
    logic       misaligned;
    logic       collides;
    range_t     other;

    always_comb begin
        other      = slots[~cfg_sel];
        active     = cfg_we && !slots[cfg_sel].lock;
        misaligned = !is_aligned(cand.base, cand.size);
        collides   = cand.en && other.en &&
                     windows_meet(cand.base, cand.size, other.base, other.size);
        set_align   = active && misaligned;
        set_overlap = active && !misaligned && collides;
    end

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_load
        assign load[gi] = active && (cfg_sel == IDX_W'(gi)) && !misaligned && !collides;
    end

endmodule

// File: rtl/frg_decide.sv
module frg_decide
    import frg_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ID_W-1:0]    id,
    input  range_t [SLOTS-1:0] slots,
    output logic [SLOTS-1:0]   match,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic               allow
);

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_match
        assign match[gi] = slots[gi].en &&
                           ({1'b0, addr} >= {1'b0, slots[gi].base}) &&
                           ({1'b0, addr} <  range_end(slots[gi].base, slots[gi].size));
    end

    always_comb begin
        hit   = 1'b0;
        idx   = '0;
        allow = 1'b1;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit   = 1'b1;
                idx   = IDX_W'(i);
                allow = (id == slots[i].owner);
            end
        end
    end

endmodule

// File: rtl/fabric_range_guard.sv
module fabric_range_guard
    import frg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [15:0]       cfg_base,
    input  logic [1:0]        cfg_size,
    input  logic [3:0]        cfg_owner,
    input  logic              cfg_en,
    input  logic              cfg_lock,
    input  logic              tx_valid,
    input  logic [15:0]       tx_addr,
    input  logic [3:0]        tx_id,
    input  logic              tx_write,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_hit,
    output logic              rsp_idx,
    output logic              rsp_write,
    output logic              cfg_err_align,
    output logic              cfg_err_overlap
);

    typedef struct packed {
        logic             valid;
        logic             allow;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             write;
        logic             err_align;
        logic             err_overlap;
    } state_t;

    state_t             st_d, st_q;
    range_t [SLOTS-1:0] slot_q;
    range_t             cand;
    logic   [SLOTS-1:0] load;
    logic   [SLOTS-1:0] match;
    logic               set_align, set_overlap;
    logic               dec_hit, dec_allow;
    logic   [IDX_W-1:0] dec_idx;

    assign cand = '{en: cfg_en, lock: cfg_lock, base: cfg_base,
                    size: cfg_size, owner: cfg_owner};

    frg_cfg_check u_cfg (
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cand        (cand),
        .slots       (slot_q),
        .load        (load),
        .set_align   (set_align),
        .set_overlap (set_overlap)
    );

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        frg_range_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load[gi]),
            .load_val (cand),
            .slot_q   (slot_q[gi])
        );
    end

    frg_decide u_dec (
        .addr  (tx_addr),
        .id    (tx_id),
        .slots (slot_q),
        .match (match),
        .hit   (dec_hit),
        .idx   (dec_idx),
        .allow (dec_allow)
    );

    always_comb begin
        st_d             = '0;
        st_d.valid       = tx_valid;
        st_d.allow       = tx_valid && dec_allow;
        st_d.hit         = tx_valid && dec_hit;
        st_d.idx         = tx_valid ? dec_idx : '0;
        st_d.write       = tx_valid && tx_write;
        st_d.err_align   = st_q.err_align   || set_align;
        st_d.err_overlap = st_q.err_overlap || set_overlap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid       = st_q.valid;
    assign rsp_allow       = st_q.allow;
    assign rsp_hit         = st_q.hit;
    assign rsp_idx         = st_q.idx;
    assign rsp_write       = st_q.write;
    assign cfg_err_align   = st_q.err_align;
    assign cfg_err_overlap = st_q.err_overlap;

    // R7: the two enabled windows never share an address
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_q[0].en && slot_q[1].en &&
          windows_meet(slot_q[0].base, slot_q[0].size, slot_q[1].base, slot_q[1].size)));

    // R4: at most one window claims an address
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R5: an unclaimed answer is always an allow
    a_r5_open_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_allow);

    // R3: answer follows the request by one cycle, quiet otherwise
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> rsp_valid);
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_allow || rsp_hit || rsp_idx || rsp_write));

    // R6 and R7: error flags are sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err_align) |-> cfg_err_align);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err_overlap) |-> cfg_err_overlap);

endmodule

// File: tb/fabric_range_guard_bench.sv
module fabric_range_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0, cfg_en = 1'b0, cfg_lock = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [1:0]  cfg_size = '0;
    logic [3:0]  cfg_owner = '0;
    logic        tx_valid = 1'b0, tx_write = 1'b0;
    logic [15:0] tx_addr = '0;
    logic [3:0]  tx_id = '0;
    logic        rsp_valid, rsp_allow, rsp_hit, rsp_idx, rsp_write;
    logic        cfg_err_align, cfg_err_overlap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fabric_range_guard u_fabric_range_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_owner(cfg_owner), .cfg_en(cfg_en), .cfg_lock(cfg_lock),
        .tx_valid(tx_valid), .tx_addr(tx_addr), .tx_id(tx_id), .tx_write(tx_write),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
        .rsp_idx(rsp_idx), .rsp_write(rsp_write),
        .cfg_err_align(cfg_err_align), .cfg_err_overlap(cfg_err_overlap)
    );

    // behavioural reference model
    int  m_base [2];
    int  m_len  [2];
    int  m_own  [2];
    bit  m_en   [2];
    bit  m_lock [2];
    bit  e_valid, e_allow, e_hit, e_idx, e_write, e_al, e_ov;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_base[i] = 0; m_len[i] = 4096; m_own[i] = 0; m_en[i] = 0; m_lock[i] = 0;
            end
            {e_valid, e_allow, e_hit, e_idx, e_write, e_al, e_ov} = '0;
        end else begin
            e_valid = tx_valid; e_allow = tx_valid; e_hit = 0; e_idx = 0;
            e_write = tx_valid && tx_write;
            if (tx_valid) begin
                for (int i = 0; i < 2; i++) begin
                    if (m_en[i] && int'(tx_addr) >= m_base[i] &&
                        int'(tx_addr) < m_base[i] + m_len[i]) begin
                        e_hit = 1; e_idx = i[0]; e_allow = (int'(tx_id) == m_own[i]);
                    end
                end
            end
            if (cfg_we && !m_lock[cfg_sel]) begin
                int len, b, o;
                len = 4096 << cfg_size;
                b = int'(cfg_base);
                o = cfg_sel ? 0 : 1;
                if (b % len != 0) e_al = 1;
                else if (cfg_en && m_en[o] && b < m_base[o] + m_len[o] && m_base[o] < b + len)
                    e_ov = 1;
                else begin
                    m_base[cfg_sel] = b; m_len[cfg_sel] = len; m_own[cfg_sel] = int'(cfg_owner);
                    m_en[cfg_sel] = cfg_en; m_lock[cfg_sel] = cfg_lock;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({rsp_valid, rsp_write} == {e_valid, e_write}, "R3 R9 valid/write",
                  {rsp_valid, rsp_write}, {e_valid, e_write});
            check({rsp_allow, rsp_hit, rsp_idx} == {e_allow, e_hit, e_idx}, "R4 R5 decision",
                  {rsp_allow, rsp_hit, rsp_idx}, {e_allow, e_hit, e_idx});
            check({cfg_err_align, cfg_err_overlap} == {e_al, e_ov}, "R6 R7 error flags",
                  {cfg_err_align, cfg_err_overlap}, {e_al, e_ov});
        end
    end

    task automatic cfg_w(input bit sel, input int base, input int code, input int own,
                         input bit en, input bit lk);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_base = 16'(base); cfg_size = 2'(code);
        cfg_owner = 4'(own); cfg_en = en; cfg_lock = lk;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic txq(input int addr, input int id, input bit wr,
                       input bit x_allow, input bit x_hit, input bit x_idx, input string tag);
        @(negedge clk);
        tx_valid = 1; tx_addr = 16'(addr); tx_id = 4'(id); tx_write = wr;
        @(negedge clk);
        tx_valid = 0;
        check({rsp_valid, rsp_allow, rsp_hit, rsp_idx, rsp_write} ==
              {1'b1, x_allow, x_hit, x_idx, wr}, tag,
              {rsp_valid, rsp_allow, rsp_hit, rsp_idx, rsp_write},
              {1'b1, x_allow, x_hit, x_idx, wr});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        check({rsp_valid, cfg_err_align, cfg_err_overlap} == 3'b000, "R1 reset outputs",
              {rsp_valid, cfg_err_align, cfg_err_overlap}, 0);
        txq(16'h5000, 3, 0, 1, 0, 0, "R1 open after reset");
        // R2 / R4 / R5: 4 KB window at 0x1000 owned by 2
        cfg_w(0, 16'h1000, 0, 2, 1, 0);
        txq(16'h1000, 2, 0, 1, 1, 0, "R4 owner allowed");
        txq(16'h1FFF, 5, 0, 0, 1, 0, "R2 last byte denied");
        txq(16'h2000, 5, 0, 1, 0, 0, "R5 first byte after window open");
        // 32 KB window at 0x8000 owned by 5, padding end
        cfg_w(1, 16'h8000, 3, 5, 1, 0);
        txq(16'hFFFF, 2, 0, 0, 1, 1, "R2 padding protected");
        txq(16'hFFFF, 5, 0, 1, 1, 1, "R4 owner on slot 1");
        txq(16'hC000, 2, 1, 0, 1, 1, "R9 write flag same decision");
        // R3: idle cycle is quiet
        @(negedge clk);
        check({rsp_valid, rsp_allow, rsp_hit} == 3'b000, "R3 idle quiet",
              {rsp_valid, rsp_allow, rsp_hit}, 0);
        // R11: disable slot 0 in the same cycle as a transaction
        @(negedge clk);
        cfg_we = 1; cfg_sel = 0; cfg_base = 16'h1000; cfg_size = 0; cfg_owner = 2;
        cfg_en = 0; cfg_lock = 0;
        tx_valid = 1; tx_addr = 16'h1000; tx_id = 7; tx_write = 0;
        @(negedge clk);
        cfg_we = 0; tx_valid = 0;
        check({rsp_allow, rsp_hit} == 2'b01, "R11 old state used", {rsp_allow, rsp_hit}, 1);
        txq(16'h1000, 7, 0, 1, 0, 0, "R10 R11 disabled slot open next");
        // R6: misaligned write refused, slot unchanged
        cfg_w(0, 16'h1000, 0, 2, 1, 0);
        cfg_w(0, 16'h3000, 1, 9, 1, 0);
        check(cfg_err_align == 1, "R6 align flag", cfg_err_align, 1);
        txq(16'h1000, 7, 0, 0, 1, 0, "R6 slot unchanged");
        txq(16'h3000, 9, 0, 1, 0, 0, "R6 rejected window not protected");
        // R7: overlap refused, then touching windows accepted
        cfg_w(0, 16'h8000, 0, 7, 1, 0);
        check(cfg_err_overlap == 1, "R7 overlap flag", cfg_err_overlap, 1);
        txq(16'h1000, 7, 0, 0, 1, 0, "R7 slot unchanged");
        cfg_w(0, 16'h7000, 0, 2, 1, 0);
        txq(16'h7FFF, 2, 0, 1, 1, 0, "R7 touching window accepted");
        txq(16'h7000, 7, 0, 0, 1, 0, "R7 touching window protected");
        // R10: disabled write inside slot 1 accepted
        cfg_w(0, 16'h8000, 0, 7, 0, 0);
        txq(16'h8000, 5, 0, 1, 1, 1, "R10 disabled slot 0 ignored");
        // R8: lock slot 1, later writes ignored without new error
        cfg_w(1, 16'h8000, 3, 5, 1, 1);
        cfg_w(1, 16'h0000, 3, 9, 1, 0);
        txq(16'h8000, 9, 0, 0, 1, 1, "R8 locked slot unchanged");
        do_reset();
        cfg_w(1, 16'h8000, 3, 5, 1, 1);
        cfg_w(1, 16'h8001, 3, 9, 1, 0);
        check(cfg_err_align == 0, "R8 locked write raises no error", cfg_err_align, 0);
        do_reset();
        cfg_w(1, 16'h0000, 2, 9, 1, 0);
        txq(16'h0000, 9, 0, 1, 1, 1, "R8 lock cleared by reset");
        // random phase against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            cfg_we    = ($urandom % 4) == 0;
            cfg_sel   = 1'($urandom);
            cfg_size  = 2'($urandom);
            cfg_base  = 16'(($urandom % 16) << 12);
            cfg_owner = 4'($urandom % 4);
            cfg_en    = ($urandom % 4) != 0;
            cfg_lock  = ($urandom % 32) == 0;
            tx_valid  = ($urandom % 3) != 0;
            tx_addr   = 16'($urandom);
            tx_id     = 4'($urandom % 4);
            tx_write  = 1'($urandom);
            if (k % 700 == 699) begin
                cfg_we = 0; tx_valid = 0;
                do_reset();
            end
        end
        @(negedge clk);
        cfg_we = 0; tx_valid = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule